// File: doc/BRIEF.md
# Quad-Lane 32:4 Serializer

The block takes a 32-bit parallel word once every eight fast-clock cycles and sends it out over four serial lanes. Each lane is an eight-stage shift register on the fast clock. Bit positions are interleaved across the lanes: lane k carries word bits k, k+4, k+8 and so on up to k+28. Every lane sends its lowest word bit first, so word bit 0 leaves on lane 0 in the first bit slot of the word.

A divide-by-eight counter sets the load point. It also drives a low-speed clock that the parallel source uses to time its words. A 2-bit phase select places the rising edge of that divided clock at one of four even offsets from the load edge, so the source can be given the setup margin it needs. The serial bits and the divided clock each come from a flop clocked by the fast clock. The fast clock is also forwarded on its own port for a receiver that clocks in the same direction as the data.

Top module: `quad_serializer`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, that edge clears the counter and every lane, and drives `serOut` to 4'b0000 and `divClk` to 0.
- R2: The word on `parWord` is captured at the first rising edge at which `rst` is low. After that it is captured at every eighth edge, and at no other edge.
- R3: Lane k (the bit `serOut[k]`) carries word bits k, k+4, k+8, ... k+28, in that order.
- R4: A word captured at edge L appears bit by bit on `serOut` after edges L+1 through L+8. After edge L+1+j each lane shows its bit j (the bit at word position k+4j). The stream has no gaps, so the next word's first bits follow directly after edge L+9.
- R5: Values on `parWord` at edges other than capture edges have no effect on `serOut`.
- R6: With `phaseSel` held, `divClk` has a period of eight `clk` cycles. It is high for four cycles and low for four.
- R7: With `phaseSel` = s (0 to 3), `divClk` goes high at the edge 2*s cycles after a capture edge. For s = 0 it goes high at the capture edge itself. Four edges later it goes low.
- R8: `fwdClk` follows the level of `clk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast serial clock |
| rst | input | 1 | Synchronous reset, active high |
| phaseSel | input | 2 | Phase of the divided clock relative to the capture edge |
| parWord | input | 32 | Parallel data word, bit 0 sent first |
| serOut | output | 4 | Serial lanes, registered |
| divClk | output | 1 | Fast clock divided by eight, registered |
| fwdClk | output | 1 | Forwarded fast clock |

## Verification
A fault in the divide-by-eight counter shows at the ports within one low-speed period. `divClk` runs longer or shorter than four cycles, or it rises at the wrong offset from the capture edge. The bits that follow on `serOut` then come from the wrong word. A fault in a lane's shift register, or in the mapping of word bits to lanes, first shows two edges after a capture. Walking-one words show it most clearly: a lone 1 appears on the wrong lane or in the wrong bit slot.

// File: rtl/qser_pkg.sv
`timescale 1ns/1ps
package qser_pkg;
  // Strobes passed from control to datapath, one fast cycle each.
  typedef struct packed {
    logic load;   // capture parallel word into lanes
    logic shift;  // advance lanes by one bit
  } serStrobe_t;
endpackage

// File: rtl/qser_ctrl.sv
`timescale 1ns/1ps
module qser_ctrl
  import qser_pkg::*;
#(
  parameter int LANE_BITS = 8,
  parameter int SEL_W     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] phaseSel,
  output serStrobe_t       strobe,
  output logic             divClk
);
  localparam int CNT_W      = $clog2(LANE_BITS);
  localparam int PHASE_STEP = LANE_BITS / (1 << SEL_W);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(LANE_BITS - 1);
  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(LANE_BITS / 2);

  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] phaseOfs;
  logic [CNT_W-1:0] relPos;
  logic             divNext;

  // Bit-slot counter: value 0 marks the capture edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      bitCnt <= '0;
    end else if (bitCnt == LAST_CNT) begin
      bitCnt <= '0;
    end else begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  // Position of the current edge relative to the selected rise point.
  always_comb begin
    phaseOfs = CNT_W'(int'(phaseSel) * PHASE_STEP);
    relPos   = bitCnt - phaseOfs;
    divNext  = (relPos < HALF_CNT);
  end

  // Divided clock is retimed at the output.
  always_ff @(posedge clk) begin
    if (rst) begin
      divClk <= 1'b0;
    end else begin
      divClk <= divNext;
    end
  end

  always_comb begin
    strobe.load  = ~rst & (bitCnt == '0);
    strobe.shift = ~rst & (bitCnt != '0);
  end
endmodule

// File: rtl/qser_lane.sv
`timescale 1ns/1ps
module qser_lane
  import qser_pkg::*;
#(
  parameter int LANE_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  serStrobe_t           strobe,
  input  logic [LANE_BITS-1:0] laneBits,
  output logic                 serBit
);
  logic [LANE_BITS-1:0] shReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      shReg <= '0;
    end else if (strobe.load) begin
      shReg <= laneBits;
    end else if (strobe.shift) begin
      shReg <= {1'b0, shReg[LANE_BITS-1:1]};
    end
  end

  // Output retiming flop, LSB leaves first.
  always_ff @(posedge clk) begin
    if (rst) begin
      serBit <= 1'b0;
    end else begin
      serBit <= shReg[0];
    end
  end
endmodule

// File: rtl/qser_datapath.sv
`timescale 1ns/1ps
module qser_datapath
  import qser_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int LANE_BITS = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  serStrobe_t                   strobe,
  input  logic [LANES*LANE_BITS-1:0]   parWord,
  output logic [LANES-1:0]             serOut
);
  for (genvar k = 0; k < LANES; k++) begin : gLane
    logic [LANE_BITS-1:0] laneBits;
    // Interleave: slot j of lane k takes word bit k + LANES*j.
    for (genvar j = 0; j < LANE_BITS; j++) begin : gSlot
      assign laneBits[j] = parWord[k + LANES*j];
    end
    qser_lane #(.LANE_BITS(LANE_BITS)) uLane (
      .clk     (clk),
      .rst     (rst),
      .strobe  (strobe),
      .laneBits(laneBits),
      .serBit  (serOut[k])
    );
  end
endmodule

// File: rtl/quad_serializer.sv
`timescale 1ns/1ps
module quad_serializer
  import qser_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int LANE_BITS = 8,
  parameter int SEL_W     = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [SEL_W-1:0]           phaseSel,
  input  logic [LANES*LANE_BITS-1:0] parWord,
  output logic [LANES-1:0]           serOut,
  output logic                       divClk,
  output logic                       fwdClk
);
  serStrobe_t strobe;

  qser_ctrl #(.LANE_BITS(LANE_BITS), .SEL_W(SEL_W)) uCtrl (
    .clk     (clk),
    .rst     (rst),
    .phaseSel(phaseSel),
    .strobe  (strobe),
    .divClk  (divClk)
  );

  qser_datapath #(.LANES(LANES), .LANE_BITS(LANE_BITS)) uData (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .parWord(parWord),
    .serOut (serOut)
  );

  // Forwarded clock with minimal skew to the retimed data.
  assign fwdClk = clk;
endmodule

// File: rtl/qser_checker.sv
`timescale 1ns/1ps
module qser_checker
  import qser_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int LANE_BITS = 8,
  parameter int SEL_W     = 2
) (
  input logic                       clk,
  input logic                       rst,
  input logic [SEL_W-1:0]           phaseSel,
  input logic [LANES*LANE_BITS-1:0] parWord,
  input logic [LANES-1:0]           serOut,
  input logic                       divClk,
  input serStrobe_t                 strobe
);
  localparam int GAP_W = $clog2(LANE_BITS) + 1;
  localparam logic [GAP_W-1:0] GAP_FULL = GAP_W'(LANE_BITS - 1);
  localparam logic [GAP_W-1:0] RUN_MAX  = GAP_W'(LANE_BITS / 2);

  logic [LANES*LANE_BITS-1:0] wordD1, wordD2;
  logic loadD1, loadD2, seenLoad, divD, warm;
  logic [SEL_W-1:0] selD;
  logic [GAP_W-1:0] gapCnt, runLen;

  always_ff @(posedge clk) begin
    if (rst) begin
      loadD1 <= 1'b0; loadD2 <= 1'b0; seenLoad <= 1'b0;
      gapCnt <= '0;
    end else begin
      loadD1 <= strobe.load; loadD2 <= loadD1;
      if (strobe.load) begin
        seenLoad <= 1'b1; gapCnt <= '0;
      end else if (gapCnt != {GAP_W{1'b1}}) begin
        gapCnt <= gapCnt + 1'b1;
      end
    end
    wordD1 <= parWord; wordD2 <= wordD1;
  end

  always_ff @(posedge clk) begin
    divD <= divClk;
    selD <= phaseSel;
    if (rst || phaseSel != selD) begin
      runLen <= '0; warm <= 1'b0;
    end else if (divClk != divD) begin
      runLen <= GAP_W'(1); warm <= 1'b1;
    end else if (runLen != {GAP_W{1'b1}}) begin
      runLen <= runLen + 1'b1;
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (serOut == '0 && !divClk));                       // R1
  AST_LOAD_SPACING: assert property (@(posedge clk) disable iff (rst)
    (strobe.load && seenLoad) |-> (gapCnt == GAP_FULL));             // R2
  AST_NO_MISSED_LOAD: assert property (@(posedge clk) disable iff (rst)
    (seenLoad && gapCnt >= GAP_FULL) |-> strobe.load);               // R2
  AST_FIRST_SLOT: assert property (@(posedge clk) disable iff (rst)
    loadD2 |-> (serOut == wordD2[LANES-1:0]));                       // R4
  AST_DIV_HALF_PERIOD: assert property (@(posedge clk) disable iff (rst)
    warm |-> (runLen <= RUN_MAX));                                   // R6
endmodule

bind quad_serializer qser_checker #(
  .LANES(LANES), .LANE_BITS(LANE_BITS), .SEL_W(SEL_W)
) uChk (
  .clk     (clk),
  .rst     (rst),
  .phaseSel(phaseSel),
  .parWord (parWord),
  .serOut  (serOut),
  .divClk  (divClk),
  .strobe  (strobe)
);

// File: tb/tb_quad_serializer.sv
`timescale 1ns/1ps
module tb_quad_serializer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  phaseSel = 2'd0;
  logic [31:0] parWord = 32'h0;
  logic [3:0]  serOut;
  logic        divClk;
  logic        fwdClk;

  int checks = 0;
  int fails  = 0;

  quad_serializer dut (
    .clk(clk), .rst(rst), .phaseSel(phaseSel), .parWord(parWord),
    .serOut(serOut), .divClk(divClk), .fwdClk(fwdClk)
  );

  always #10 clk = ~clk;  // 50 MHz

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] wordOf(input int seed, input int n);
    case (seed)
      0:       return (n % 2 == 0) ? 32'hFFFF_FFFF : 32'h0000_0000;
      1:       return 32'h1 << (n % 32);
      default: return (32'(n + 1) * 32'h9E37_79B9) ^ (32'(seed) * 32'h7F4A_7C15);
    endcase
  endfunction

  // Holds reset for three edges, checks the cleared outputs, releases at a negedge.
  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    parWord = $urandom;
    repeat (3) @(negedge clk);
    check("R1 serOut in reset", {28'h0, serOut}, 32'h0);
    check("R1 divClk in reset", {31'h0, divClk}, 32'h0);
    rst = 1'b0;
  endtask

  // Streams nWords words with phase sel; garbage on parWord between capture edges.
  task automatic runStream(input logic [1:0] sel, input int seed, input int nWords);
    logic [31:0] w;
    logic [3:0]  expBits;
    logic        expDiv;
    phaseSel = sel;
    doReset();
    parWord = wordOf(seed, 0);           // present before the first capture edge
    for (int t = 0; t <= 8 * nWords; t++) begin
      @(negedge clk);                    // edge t has occurred
      expDiv = ((((t - 2 * int'(sel)) % 8) + 8) % 8) < 4;
      check($sformatf("R6 R7 divClk sel=%0d t=%0d", sel, t), {31'h0, divClk}, {31'h0, expDiv});
      if (t >= 1) begin
        w = wordOf(seed, (t - 1) / 8);
        for (int k = 0; k < 4; k++) expBits[k] = w[k + 4 * ((t - 1) % 8)];
        check($sformatf("R2 R3 R4 R5 serOut seed=%0d t=%0d", seed, t),
              {28'h0, serOut}, {28'h0, expBits});
      end
      if ((t + 1) % 8 == 0) parWord = wordOf(seed, (t + 1) / 8);
      else                  parWord = $urandom;
    end
  endtask

  task automatic fwdClkTest();
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #5;
      check("R8 fwdClk high phase", {31'h0, fwdClk}, 32'h1);
      @(negedge clk); #5;
      check("R8 fwdClk low phase", {31'h0, fwdClk}, 32'h0);
    end
  endtask

  // Reset asserted in the middle of a stream clears outputs after one edge.
  task automatic midStreamReset();
    phaseSel = 2'd1;
    doReset();
    for (int i = 0; i < 13; i++) begin
      parWord = 32'hFFFF_FFFF;
      @(negedge clk);
    end
    rst = 1'b1;
    @(negedge clk);
    check("R1 serOut after mid-stream reset", {28'h0, serOut}, 32'h0);
    check("R1 divClk after mid-stream reset", {31'h0, divClk}, 32'h0);
  endtask

  initial begin
    runStream(2'd0, 0, 4);
    runStream(2'd1, 1, 33);
    midStreamReset();
    runStream(2'd2, 2, 6);
    runStream(2'd3, 3, 6);
    fwdClkTest();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule